// File: doc/BRIEF.md
# Register file with rename tags

This block holds the architectural integer registers of an out-of-order core. Besides its value, each register carries the tag of the in-flight instruction that will next write it, plus a dependency state that is either READY (the stored value is current) or PENDING (a producer is still in flight). The issue stage uses the file to resolve operands. The commit stage uses it to retire results.

At issue, each enabled source is looked up and a registered result is returned: the committed value, the producer tag and the ready flag. At the same time the destination of the issuing instruction takes the issue tag and moves to PENDING. At commit, the retired value is written. The register goes back to READY only if the committing tag is still the register's latest producer. Issue and commit may occur in the same clock cycle.

Each register is a two-state machine. The states are ST_READY and ST_PENDING, and the transitions are:

- **claim**: any state to ST_PENDING, loading the new tag.
- **release**: ST_PENDING to ST_READY, on a commit whose tag matches.
- **stay**: all other cases.

Register 0 has no state machine. It is hard-wired to zero.

Top module: `rename_regfile`

## Requirements
- R1: After reset every register reads as value 0, tag 0, ready 1.
- R2: Source outputs are registered. They change on the clock edge at which `iss_valid` and that source's enable are both high. Otherwise they hold their previous values.
- R3: A commit writes `cmt_data` into register `cmt_idx` only when both `cmt_valid` and `cmt_has_dst` are 1. With `cmt_has_dst` 0, nothing changes.
- R4: A written commit moves the register to READY only if `cmt_tag` equals the register's stored producer tag. Otherwise the value is still written, but the register stays PENDING with its tag unchanged.
- R5: If an issue reads a source register equal to `cmt_idx` while a commit with `cmt_has_dst` 1 is present in the same cycle, that source returns `cmt_data`, tag 0 and ready 1. This holds regardless of tags.
- R6: An issue with `dst_en` 1 stores `iss_tag` as the producer of `dst_idx` and makes it PENDING. A source read in that same issue sees the state from before the claim.
- R7: When an issue claims and a commit writes the same register in one cycle, the commit value is stored, and the register ends PENDING with the new issue tag.
- R8: Register 0 always reads value 0, tag 0, ready 1. It ignores claims, commits and bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Instruction issuing this cycle |
| iss_tag | input | TAG_W | Tag of the issuing instruction |
| src_a_en | input | 1 | Source A present |
| src_a_idx | input | IDX_W | Source A register |
| src_b_en | input | 1 | Source B present |
| src_b_idx | input | IDX_W | Source B register |
| dst_en | input | 1 | Destination present |
| dst_idx | input | IDX_W | Destination register |
| cmt_valid | input | 1 | Instruction committing this cycle |
| cmt_has_dst | input | 1 | Committing instruction writes a register |
| cmt_tag | input | TAG_W | Tag of the committing instruction |
| cmt_idx | input | IDX_W | Register written by the commit |
| cmt_data | input | DATA_W | Value written by the commit |
| a_value | output | DATA_W | Source A value |
| a_tag | output | TAG_W | Source A producer tag |
| a_ready | output | 1 | Source A has no pending producer |
| b_value | output | DATA_W | Source B value |
| b_tag | output | TAG_W | Source B producer tag |
| b_ready | output | 1 | Source B has no pending producer |

## Verification
Issue and commit are the two functions that can land in the same cycle. The bench provokes this in two ways. First, it drives a commit on the very cycle that an issue reads the committing register, which exercises the bypass. Second, it drives an issue that claims the register being committed. In both cases it then reads the register again in a later, quiet cycle. The judgement is made from the registered source outputs: the bypassed triple in the same cycle, then the stored value together with the producer tag that won.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    typedef enum logic {
        ST_READY   = 1'b0,
        ST_PENDING = 1'b1
    } dep_state_t;
endpackage

// File: rtl/rrf_entry.sv
module rrf_entry #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [TAG_W-1:0]  cmt_tag_i,
    input  logic              claim_i,
    input  logic [TAG_W-1:0]  claim_tag_i,
    output logic [DATA_W-1:0] value_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic              ready_o
);
    import rrf_pkg::*;

    dep_state_t        state_q, state_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] value_q;

    // next state: claim wins over release
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (state_q)
            ST_READY: begin
                if (claim_i) begin
                    state_d = ST_PENDING;
                    tag_d   = claim_tag_i;
                end
            end
            ST_PENDING: begin
                if (claim_i) begin
                    tag_d = claim_tag_i;
                end else if (wr_en_i && (cmt_tag_i == tag_q)) begin
                    state_d = ST_READY;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       value_q <= '0;
        else if (wr_en_i) value_q <= wr_data_i;
    end

    always_comb begin
        value_o = value_q;
        tag_o   = tag_q;
        ready_o = (state_q == ST_READY);
    end

    a_r3_value_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(value_o));

    a_r4_mismatch_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !claim_i && wr_en_i && (cmt_tag_i != tag_o)) |=> (!ready_o && $stable(tag_o)));

    a_r6_claim_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |=> (!ready_o && (tag_o == $past(claim_tag_i))));

    a_r7_claim_beats_release: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_i && wr_en_i) |=> (!ready_o && (value_o == $past(wr_data_i))));
endmodule

// File: rtl/rrf_read_port.sv
module rrf_read_port #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en_i,
    input  logic [IDX_W-1:0]             rd_idx_i,
    input  logic                         byp_en_i,
    input  logic [IDX_W-1:0]             byp_idx_i,
    input  logic [DATA_W-1:0]            byp_data_i,
    input  logic [NREG-1:0][DATA_W-1:0]  vals_i,
    input  logic [NREG-1:0][TAG_W-1:0]   tags_i,
    input  logic [NREG-1:0]              ready_i,
    output logic [DATA_W-1:0]            value_o,
    output logic [TAG_W-1:0]             tag_o,
    output logic                         ready_o
);
    logic              is_zero, is_byp;
    logic [DATA_W-1:0] value_d;
    logic [TAG_W-1:0]  tag_d;
    logic              ready_d;

    always_comb begin
        is_zero = (rd_idx_i == '0);
        is_byp  = byp_en_i && (byp_idx_i == rd_idx_i);
        if (is_zero) begin
            value_d = '0;
            tag_d   = '0;
            ready_d = 1'b1;
        end else if (is_byp) begin
            value_d = byp_data_i;
            tag_d   = '0;
            ready_d = 1'b1;
        end else begin
            value_d = vals_i[rd_idx_i];
            tag_d   = tags_i[rd_idx_i];
            ready_d = ready_i[rd_idx_i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_o <= '0;
            tag_o   <= '0;
            ready_o <= 1'b1;
        end else if (rd_en_i) begin
            value_o <= value_d;
            tag_o   <= tag_d;
            ready_o <= ready_d;
        end
    end

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> ($stable(value_o) && $stable(tag_o) && $stable(ready_o)));

    a_r5_bypass_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && byp_en_i && (byp_idx_i == rd_idx_i) && (rd_idx_i != '0))
        |=> (ready_o && (tag_o == '0) && (value_o == $past(byp_data_i))));

    a_r8_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (rd_idx_i == '0)) |=> (ready_o && (tag_o == '0) && (value_o == '0)));
endmodule

// File: rtl/rename_regfile.sv
module rename_regfile #(
    parameter int NREG   = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              src_a_en,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic              src_b_en,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic              dst_en,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic              cmt_valid,
    input  logic              cmt_has_dst,
    input  logic [TAG_W-1:0]  cmt_tag,
    input  logic [IDX_W-1:0]  cmt_idx,
    input  logic [DATA_W-1:0] cmt_data,
    output logic [DATA_W-1:0] a_value,
    output logic [TAG_W-1:0]  a_tag,
    output logic              a_ready,
    output logic [DATA_W-1:0] b_value,
    output logic [TAG_W-1:0]  b_tag,
    output logic              b_ready
);
    logic [NREG-1:0][DATA_W-1:0] vals;
    logic [NREG-1:0][TAG_W-1:0]  tags;
    logic [NREG-1:0]             readies;
    logic                        cmt_wr;

    assign cmt_wr = cmt_valid && cmt_has_dst;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign vals[i]    = '0;
            assign tags[i]    = '0;
            assign readies[i] = 1'b1;
        end else begin : g_live
            logic claim, wr;
            assign claim = iss_valid && dst_en && (dst_idx == IDX_W'(i));
            assign wr    = cmt_wr && (cmt_idx == IDX_W'(i));
            rrf_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_entry (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en_i     (wr),
                .wr_data_i   (cmt_data),
                .cmt_tag_i   (cmt_tag),
                .claim_i     (claim),
                .claim_tag_i (iss_tag),
                .value_o     (vals[i]),
                .tag_o       (tags[i]),
                .ready_o     (readies[i])
            );
        end
    end

    rrf_read_port #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_port_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (iss_valid && src_a_en),
        .rd_idx_i   (src_a_idx),
        .byp_en_i   (cmt_wr),
        .byp_idx_i  (cmt_idx),
        .byp_data_i (cmt_data),
        .vals_i     (vals),
        .tags_i     (tags),
        .ready_i    (readies),
        .value_o    (a_value),
        .tag_o      (a_tag),
        .ready_o    (a_ready)
    );

    rrf_read_port #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_port_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (iss_valid && src_b_en),
        .rd_idx_i   (src_b_idx),
        .byp_en_i   (cmt_wr),
        .byp_idx_i  (cmt_idx),
        .byp_data_i (cmt_data),
        .vals_i     (vals),
        .tags_i     (tags),
        .ready_i    (readies),
        .value_o    (b_value),
        .tag_o      (b_tag),
        .ready_o    (b_ready)
    );

    a_r1_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (a_ready && b_ready && (a_tag == '0) && (b_value == '0)));
endmodule

// File: tb/tb_rename_regfile.sv
module tb_rename_regfile;
    localparam int NREG = 32, DATA_W = 32, TAG_W = 5, IDX_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic iss_valid = 0, src_a_en = 0, src_b_en = 0, dst_en = 0;
    logic [TAG_W-1:0] iss_tag = '0, cmt_tag = '0;
    logic [IDX_W-1:0] src_a_idx = '0, src_b_idx = '0, dst_idx = '0, cmt_idx = '0;
    logic cmt_valid = 0, cmt_has_dst = 0;
    logic [DATA_W-1:0] cmt_data = '0;
    logic [DATA_W-1:0] a_value, b_value;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic              a_ready, b_ready;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rename_regfile #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 0; src_a_en = 0; src_b_en = 0; dst_en = 0;
        cmt_valid = 0; cmt_has_dst = 0;
    endtask

    task automatic chk_a(string req, logic [31:0] v, logic [4:0] t, logic r);
        chk(req, "a_value", a_value, v);
        chk(req, "a_tag", 32'(a_tag), 32'(t));
        chk(req, "a_ready", 32'(a_ready), 32'(r));
    endtask

    task automatic chk_b(string req, logic [31:0] v, logic [4:0] t, logic r);
        chk(req, "b_value", b_value, v);
        chk(req, "b_tag", 32'(b_tag), 32'(t));
        chk(req, "b_ready", 32'(b_ready), 32'(r));
    endtask

    task automatic read2(int ra, int rb);
        idle();
        iss_valid = 1; src_a_en = 1; src_a_idx = IDX_W'(ra);
        src_b_en = 1; src_b_idx = IDX_W'(rb);
        step();
        idle();
    endtask

    task automatic claim(int r, int t);
        idle();
        iss_valid = 1; dst_en = 1; dst_idx = IDX_W'(r); iss_tag = TAG_W'(t);
        step();
        idle();
    endtask

    task automatic commit(int r, int t, logic [31:0] d, logic has_dst);
        idle();
        cmt_valid = 1; cmt_has_dst = has_dst; cmt_idx = IDX_W'(r);
        cmt_tag = TAG_W'(t); cmt_data = d;
        step();
        idle();
    endtask

    task automatic t_reset();
        chk_a("R1", 0, 0, 1);
        read2(5, 31);
        chk_a("R1", 0, 0, 1);
        chk_b("R1", 0, 0, 1);
    endtask

    task automatic t_claim();
        // source of the claiming issue sees the old state
        idle();
        iss_valid = 1; dst_en = 1; dst_idx = 5; iss_tag = 7;
        src_a_en = 1; src_a_idx = 5;
        step(); idle();
        chk_a("R6", 0, 0, 1);
        read2(5, 1);
        chk_a("R6", 0, 7, 0);
    endtask

    task automatic t_tag_match();
        commit(5, 3, 32'hAAAA_0001, 1);
        read2(5, 0);
        chk_a("R4", 32'hAAAA_0001, 7, 0);
        commit(5, 7, 32'hBBBB_0002, 1);
        read2(5, 0);
        chk_a("R4", 32'hBBBB_0002, 7, 1);
    endtask

    task automatic t_no_dst();
        claim(9, 11);
        commit(9, 11, 32'hCCCC_0003, 0);
        read2(1, 9);
        chk_b("R3", 0, 11, 0);
        commit(5, 7, 32'hDDDD_0004, 0);
        read2(5, 5);
        chk_a("R3", 32'hBBBB_0002, 7, 1);
    endtask

    task automatic t_bypass();
        claim(6, 9);
        idle();
        cmt_valid = 1; cmt_has_dst = 1; cmt_idx = 6; cmt_tag = 9; cmt_data = 32'h0000_1234;
        iss_valid = 1; src_a_en = 1; src_a_idx = 6; src_b_en = 1; src_b_idx = 5;
        step(); idle();
        chk_a("R5", 32'h0000_1234, 0, 1);
        chk_b("R5", 32'hBBBB_0002, 7, 1);
        read2(6, 6);
        chk_a("R5", 32'h0000_1234, 9, 1);
        // tag mismatch still bypasses
        claim(7, 10);
        idle();
        cmt_valid = 1; cmt_has_dst = 1; cmt_idx = 7; cmt_tag = 2; cmt_data = 32'h55;
        iss_valid = 1; src_b_en = 1; src_b_idx = 7;
        step(); idle();
        chk_b("R5", 32'h55, 0, 1);
        read2(7, 7);
        chk_a("R4", 32'h55, 10, 0);
    endtask

    task automatic t_same_dst();
        claim(8, 4);
        idle();
        iss_valid = 1; dst_en = 1; dst_idx = 8; iss_tag = 12;
        cmt_valid = 1; cmt_has_dst = 1; cmt_idx = 8; cmt_tag = 4; cmt_data = 32'h77;
        step(); idle();
        read2(8, 8);
        chk_a("R7", 32'h77, 12, 0);
        commit(8, 12, 32'h78, 1);
        read2(8, 8);
        chk_b("R7", 32'h78, 12, 1);
    endtask

    task automatic t_zero();
        claim(0, 3);
        commit(0, 3, 32'hFFFF_FFFF, 1);
        read2(0, 0);
        chk_a("R8", 0, 0, 1);
        idle();
        cmt_valid = 1; cmt_has_dst = 1; cmt_idx = 0; cmt_tag = 0; cmt_data = 32'hFEED;
        iss_valid = 1; src_b_en = 1; src_b_idx = 0;
        step(); idle();
        chk_b("R8", 0, 0, 1);
    endtask

    task automatic t_hold();
        read2(7, 6); // a=(55,10,0) b=(1234,9,1)
        idle();
        src_a_en = 1; src_a_idx = 5; src_b_en = 1; src_b_idx = 8;
        step(); idle();
        chk_a("R2", 32'h55, 10, 0);
        chk_b("R2", 32'h0000_1234, 9, 1);
        idle();
        iss_valid = 1; src_a_en = 1; src_a_idx = 5; src_b_en = 0; src_b_idx = 8;
        step(); idle();
        chk_a("R2", 32'hBBBB_0002, 7, 1);
        chk_b("R2", 32'h0000_1234, 9, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_claim();
        t_tag_match();
        t_no_dst();
        t_bypass();
        t_same_dst();
        t_zero();
        t_hold();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule